// File: doc/BRIEF.md
# FEC Transmit Delimiter Rewriter and Parity Inserter

This block sits in the transmit path of a 10 Gbit/s passive optical network physical layer. It works on a stream of decoded line symbols, one per clock, each carrying a control flag and an 8-bit code. When forward error correction is switched on, it recognises the short idle-to-start and terminate-to-idle patterns of ordinary Ethernet frames. It rewrites them into the longer FEC frame markers. It then fills the widened interframe gap with parity bytes drawn from a first-word-fall-through parity FIFO, and seals the parity run with a closing end marker. When FEC is switched off, the stream goes through untouched.

The block delays every symbol by a fixed pipeline of `DLY + 1` cycles (5 by default). This gives it enough lookahead to replace a three-symbol match in place, and the longer markers take the place of idles that the upstream gap extension has already added. Parity generation, line coding and the gap extension itself are done elsewhere. Frames carry data bytes only between their delimiters.

Symbol encoding (control flag in bit 8): idle `1_07`, start `1_FB`, terminate `1_FD`, reserved-idle R `1_F7`, comma `1_BC`, and the alignment byte `0_C6`, which is a data symbol. Below, I, S, T, R, K and D name these six.

Top module: `fec_delim_inserter`

## Requirements
- R1: With `fec_en` low, each output symbol equals the input symbol from exactly DLY+1 = 5 cycles earlier, and no pattern is rewritten.
- R2: After reset the output symbol is I, `err_o` is 0 and `par_pop_o` is 0.
- R3: With `fec_en` high and outside a frame, an input I,I,S rewrites the output as K,D,K,D,S. The S keeps its own slot, and the two slots before the I,I pair (which must be idles) carry the first K,D.
- R4: In a frame, counting the S as position 0, a T,R,I whose T lands on an even position is output as T,R,I,T,R. The last two slots replace idles.
- R5: A T,R,I whose T lands on an odd position is output as T,R,R,I,T,R. The last three slots replace idles.
- R6: After the first end marker, each gap idle is replaced by the FIFO head byte as a data symbol while the FIFO is non-empty. `par_pop_o` pulses in that same cycle, and the bytes keep FIFO order.
- R7: When the FIFO is empty at a gap slot, T,R,I,T,R is sent over five idle slots, and idles then pass through until the next start pattern.
- R8: A non-idle symbol found where an idle is needed (a gap slot during parity, or a slot overwritten by an end marker) drives `err_o` high in that symbol's output cycle. During parity, that symbol is passed on and the parity run is abandoned.
- R9: `par_pop_o` is never high unless `par_valid_i` and `fec_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fec_en | input | 1 | FEC rewriting enable |
| sym_ctl_i | input | 1 | Input symbol control flag |
| sym_code_i | input | 8 | Input symbol code |
| par_valid_i | input | 1 | Parity FIFO non-empty |
| par_data_i | input | 8 | Parity FIFO head byte |
| par_pop_o | output | 1 | Parity FIFO read strobe |
| sym_ctl_o | output | 1 | Output symbol control flag |
| sym_code_o | output | 8 | Output symbol code |
| err_o | output | 1 | Gap or overwrite violation, aligned with the output symbol |

## Verification
Every output slot, rewritten or not, shows up exactly five clock edges after the input symbol it belongs to, and `err_o` is aligned with that same slot. The bench therefore keeps, for each input vector, the expected output symbol and error bit. It compares vector k at the falling edge five cycles after driving it. `par_pop_o` is combinational and shares the edge on which the parity byte is registered. For that reason the bench's FIFO model advances on that edge, and the bench checks the number of bytes consumed once a scenario has drained.

// File: rtl/fec_dlm_pkg.sv
package fec_dlm_pkg;

   typedef struct packed {
      logic       ctl;
      logic [7:0] code;
   } sym_t;

   localparam sym_t SYM_IDLE  = 9'h107;
   localparam sym_t SYM_START = 9'h1FB;
   localparam sym_t SYM_TERM  = 9'h1FD;
   localparam sym_t SYM_RES   = 9'h1F7;
   localparam sym_t SYM_COMMA = 9'h1BC;
   localparam sym_t SYM_ALIGN = 9'h0C6;

   typedef enum logic [1:0] {DK_SOF, DK_EVEN, DK_ODD, DK_CLOSE} dkind_e;

   typedef enum logic [1:0] {ST_GAP, ST_EMIT, ST_FRAME, ST_PARITY} dstate_e;

   // index of the final symbol of each marker
   function automatic logic [2:0] dlm_last(input dkind_e k);
      return (k == DK_ODD) ? 3'd5 : 3'd4;
   endfunction

   function automatic sym_t dlm_sym(input dkind_e k, input logic [2:0] i);
      sym_t s;
      case (k)
         DK_SOF: begin
            case (i)
               3'd0, 3'd2: s = SYM_COMMA;
               3'd1, 3'd3: s = SYM_ALIGN;
               default:    s = SYM_START;
            endcase
         end
         DK_ODD: begin
            case (i)
               3'd0, 3'd4: s = SYM_TERM;
               3'd3:       s = SYM_IDLE;
               default:    s = SYM_RES;
            endcase
         end
         default: begin
            case (i)
               3'd0, 3'd3: s = SYM_TERM;
               3'd2:       s = SYM_IDLE;
               default:    s = SYM_RES;
            endcase
         end
      endcase
      return s;
   endfunction

   // slots whose original content must be an idle
   function automatic logic dlm_need_idle(input dkind_e k, input logic [2:0] i);
      case (k)
         DK_SOF:   return 1'b0;
         DK_CLOSE: return 1'b1;
         default:  return (i >= 3'd3);
      endcase
   endfunction

endpackage

// File: rtl/fec_dlm_delay.sv
module fec_dlm_delay
   import fec_dlm_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sym_t             sym_i,
   output sym_t [DEPTH:0]   win_o
);

   sym_t [DEPTH-1:0] stage;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_stage
         if (g == DEPTH - 1) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[g] <= SYM_IDLE;
               else        stage[g] <= sym_i;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[g] <= SYM_IDLE;
               else        stage[g] <= stage[g+1];
            end
         end
         assign win_o[g] = stage[g];
      end
   endgenerate

   assign win_o[DEPTH] = sym_i;

endmodule

// File: rtl/fec_dlm_match.sv
module fec_dlm_match
   import fec_dlm_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  sym_t [DEPTH:0] win_i,
   output logic           sof_hit_o,
   output logic           eof_hit_o
);

   // start pattern sits so that its S reaches the output tap on marker slot 4
   assign sof_hit_o = (win_i[4] == SYM_START) && (win_i[3] == SYM_IDLE) &&
                      (win_i[2] == SYM_IDLE);

   // end pattern begins at the output tap
   assign eof_hit_o = (win_i[0] == SYM_TERM) && (win_i[1] == SYM_RES) &&
                      (win_i[2] == SYM_IDLE);

endmodule

// File: rtl/fec_dlm_fsm.sv
module fec_dlm_fsm
   import fec_dlm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fec_en_i,
   input  logic       sof_hit_i,
   input  logic       eof_hit_i,
   input  sym_t       tap_i,
   input  logic       par_valid_i,
   input  logic [7:0] par_data_i,
   output sym_t       sym_o,
   output logic       err_o,
   output logic       pop_o
);

   dstate_e    st, st_n;
   dkind_e     kind, kind_n;
   logic [2:0] idx, idx_n;
   logic       odd, odd_n;
   logic       tap_idle;

   assign tap_idle = (tap_i == SYM_IDLE);

   always_comb begin
      st_n   = st;
      kind_n = kind;
      idx_n  = idx;
      odd_n  = odd;
      sym_o  = tap_i;
      err_o  = 1'b0;
      pop_o  = 1'b0;
      if (!fec_en_i) begin
         st_n  = ST_GAP;
         idx_n = '0;
      end else begin
         case (st)
            ST_GAP: begin
               if (sof_hit_i) begin
                  sym_o  = dlm_sym(DK_SOF, 3'd0);
                  kind_n = DK_SOF;
                  idx_n  = 3'd1;
                  st_n   = ST_EMIT;
               end
            end
            ST_FRAME: begin
               if (eof_hit_i) begin
                  kind_n = odd ? DK_ODD : DK_EVEN;
                  sym_o  = dlm_sym(kind_n, 3'd0);
                  idx_n  = 3'd1;
                  st_n   = ST_EMIT;
               end else begin
                  odd_n = ~odd;
               end
            end
            ST_EMIT: begin
               sym_o = dlm_sym(kind, idx);
               err_o = dlm_need_idle(kind, idx) && !tap_idle;
               if (idx == dlm_last(kind)) begin
                  idx_n = '0;
                  odd_n = 1'b1;
                  case (kind)
                     DK_SOF:   st_n = ST_FRAME;
                     DK_CLOSE: st_n = ST_GAP;
                     default:  st_n = ST_PARITY;
                  endcase
               end else begin
                  idx_n = idx + 3'd1;
               end
            end
            default: begin
               if (!par_valid_i) begin
                  sym_o  = dlm_sym(DK_CLOSE, 3'd0);
                  err_o  = !tap_idle;
                  kind_n = DK_CLOSE;
                  idx_n  = 3'd1;
                  st_n   = ST_EMIT;
               end else if (tap_idle) begin
                  sym_o = {1'b0, par_data_i};
                  pop_o = 1'b1;
               end else begin
                  err_o = 1'b1;
                  st_n  = ST_GAP;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_GAP;
         kind <= DK_SOF;
         idx  <= '0;
         odd  <= 1'b0;
      end else begin
         st   <= st_n;
         kind <= kind_n;
         idx  <= idx_n;
         odd  <= odd_n;
      end
   end

endmodule

// File: rtl/fec_delim_inserter.sv
module fec_delim_inserter
   import fec_dlm_pkg::*;
#(
   parameter int DLY = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fec_en,
   input  logic       sym_ctl_i,
   input  logic [7:0] sym_code_i,
   input  logic       par_valid_i,
   input  logic [7:0] par_data_i,
   output logic       par_pop_o,
   output logic       sym_ctl_o,
   output logic [7:0] sym_code_o,
   output logic       err_o
);

   localparam int WIN = DLY + 1;

   generate
      if (DLY < 4) begin : g_bad_dly
         $error("fec_delim_inserter: DLY must be at least 4");
      end
   endgenerate

   sym_t             sym_in, sym_nxt, sym_q;
   sym_t [WIN-1:0]   win;
   logic             sof_hit, eof_hit, err_nxt;

   assign sym_in = {sym_ctl_i, sym_code_i};

   fec_dlm_delay #(.DEPTH(DLY)) i_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .sym_i (sym_in),
      .win_o (win)
   );

   fec_dlm_match #(.DEPTH(DLY)) i_match (
      .win_i     (win),
      .sof_hit_o (sof_hit),
      .eof_hit_o (eof_hit)
   );

   fec_dlm_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fec_en_i    (fec_en),
      .sof_hit_i   (sof_hit),
      .eof_hit_i   (eof_hit),
      .tap_i       (win[0]),
      .par_valid_i (par_valid_i),
      .par_data_i  (par_data_i),
      .sym_o       (sym_nxt),
      .err_o       (err_nxt),
      .pop_o       (par_pop_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q <= SYM_IDLE;
         err_o <= 1'b0;
      end else begin
         sym_q <= sym_nxt;
         err_o <= err_nxt;
      end
   end

   assign sym_ctl_o  = sym_q.ctl;
   assign sym_code_o = sym_q.code;

endmodule

// File: rtl/fec_delim_inserter_chk.sv
module fec_delim_inserter_chk #(
   parameter int DLY = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       fec_en,
   input logic       sym_ctl_i,
   input logic [7:0] sym_code_i,
   input logic       par_valid_i,
   input logic [7:0] par_data_i,
   input logic       par_pop_o,
   input logic       sym_ctl_o,
   input logic [7:0] sym_code_o,
   input logic       err_o
);

   logic [3:0] dis_run;
   logic [8:0] so;

   assign so = {sym_ctl_o, sym_code_o};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dis_run <= '0;
      else if (fec_en)  dis_run <= '0;
      else if (dis_run != 4'hF) dis_run <= dis_run + 4'd1;
   end

   generate
      if (DLY == 4) begin : g_bypass
         assert_bypass_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_run >= 4'd5) |-> (so == $past({sym_ctl_i, sym_code_i}, 5)));
      end
   endgenerate

   assert_comma_then_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (so == 9'h1BC && $past(fec_en) && fec_en) |=> (so == 9'h0C6));

   assert_pop_byte_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      par_pop_o |=> (so == {1'b0, $past(par_data_i)}));

   assert_err_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(fec_en));

   assert_pop_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      par_pop_o |-> (par_valid_i && fec_en));

endmodule

bind fec_delim_inserter fec_delim_inserter_chk #(.DLY(DLY)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fec_en      (fec_en),
   .sym_ctl_i   (sym_ctl_i),
   .sym_code_i  (sym_code_i),
   .par_valid_i (par_valid_i),
   .par_data_i  (par_data_i),
   .par_pop_o   (par_pop_o),
   .sym_ctl_o   (sym_ctl_o),
   .sym_code_o  (sym_code_o),
   .err_o       (err_o)
);

// File: tb/test_fec_delim_inserter.sv
module test_fec_delim_inserter;

   localparam int LAT = 5;
   localparam logic [8:0] I_ = 9'h107, S_ = 9'h1FB, T_ = 9'h1FD, R_ = 9'h1F7;
   localparam logic [8:0] K_ = 9'h1BC, D_ = 9'h0C6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, fec_en, sym_ctl_i, par_valid_i, par_pop_o, sym_ctl_o, err_o;
   logic [7:0] sym_code_i, par_data_i, sym_code_o;

   fec_delim_inserter i_fec_delim_inserter (
      .clk(clk), .rst_n(rst_n), .fec_en(fec_en),
      .sym_ctl_i(sym_ctl_i), .sym_code_i(sym_code_i),
      .par_valid_i(par_valid_i), .par_data_i(par_data_i), .par_pop_o(par_pop_o),
      .sym_ctl_o(sym_ctl_o), .sym_code_o(sym_code_o), .err_o(err_o)
   );

   int n_chk = 0, n_bad = 0;
   logic [8:0] stim [64];
   logic [8:0] expv [64];
   logic       experr [64];
   string      tagv [64];
   int         n;

   logic [7:0] fmem [8];
   int         fcnt;
   int         fidx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fidx <= 0;
      else if (par_pop_o) fidx <= fidx + 1;
   end
   assign par_valid_i = (fidx < fcnt);
   assign par_data_i  = (fidx < 8) ? fmem[fidx] : 8'h00;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic add(input logic [8:0] si, input logic [8:0] se, input logic e, input string t);
      stim[n] = si; expv[n] = se; experr[n] = e; tagv[n] = t; n++;
   endtask

   task automatic start(input logic en, input int pcnt);
      rst_n = 1'b0; fec_en = en; {sym_ctl_i, sym_code_i} = I_; n = 0;
      fcnt = pcnt;
      for (int i = 0; i < 8; i++) fmem[i] = 8'hA0 + 8'(i);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run();
      for (int k = 0; k < n + LAT; k++) begin
         @(negedge clk);
         if (k >= LAT) begin
            chk(tagv[k-LAT], int'({sym_ctl_o, sym_code_o}), int'(expv[k-LAT]));
            chk(tagv[k-LAT], int'(err_o), int'(experr[k-LAT]));
         end
         {sym_ctl_i, sym_code_i} = (k < n) ? stim[k] : I_;
      end
   endtask

   task automatic add_sof();
      add(I_, I_, 0, "R3"); add(I_, I_, 0, "R3");
      add(I_, K_, 0, "R3"); add(I_, D_, 0, "R3");
      add(I_, K_, 0, "R3"); add(I_, D_, 0, "R3");
      add(S_, S_, 0, "R3");
   endtask

   task automatic add_data(input int cnt);
      for (int i = 0; i < cnt; i++) add({1'b0, 8'h30 + 8'(i)}, {1'b0, 8'h30 + 8'(i)}, 0, "R3");
   endtask

   task automatic add_even();
      add(T_, T_, 0, "R4"); add(R_, R_, 0, "R4"); add(I_, I_, 0, "R4");
      add(I_, T_, 0, "R4"); add(I_, R_, 0, "R4");
   endtask

   task automatic add_parity(input int cnt);
      for (int i = 0; i < cnt; i++) add(I_, {1'b0, 8'hA0 + 8'(i)}, 0, "R6");
   endtask

   task automatic add_close();
      add(I_, T_, 0, "R7"); add(I_, R_, 0, "R7"); add(I_, I_, 0, "R7");
      add(I_, T_, 0, "R7"); add(I_, R_, 0, "R7");
      for (int i = 0; i < 3; i++) add(I_, I_, 0, "R7");
   endtask

   task automatic t_reset();
      start(1'b1, 0);
      @(negedge clk);
      chk("R2 sym", int'({sym_ctl_o, sym_code_o}), int'(I_));
      chk("R2 err", int'(err_o), 0);
      chk("R2 pop", int'(par_pop_o), 0);
   endtask

   task automatic t_bypass();
      start(1'b0, 3);
      add(I_, I_, 0, "R1"); add(I_, I_, 0, "R1"); add(S_, S_, 0, "R1");
      add(9'h012, 9'h012, 0, "R1"); add(T_, T_, 0, "R1"); add(R_, R_, 0, "R1");
      for (int i = 0; i < 4; i++) add(I_, I_, 0, "R1");
      run();
      chk("R9 no pop when disabled", fidx, 0);
   endtask

   task automatic t_even();
      start(1'b1, 3);
      add_sof(); add_data(3); add_even(); add_parity(3); add_close();
      run();
      chk("R6 bytes consumed", fidx, 3);
   endtask

   task automatic t_odd();
      start(1'b1, 2);
      add_sof(); add_data(2);
      add(T_, T_, 0, "R5"); add(R_, R_, 0, "R5"); add(I_, R_, 0, "R5");
      add(I_, I_, 0, "R5"); add(I_, T_, 0, "R5"); add(I_, R_, 0, "R5");
      add_parity(2); add_close();
      run();
      chk("R6 bytes consumed odd", fidx, 2);
   endtask

   task automatic t_empty();
      start(1'b1, 0);
      add_sof(); add_data(1); add_even(); add_close();
      run();
      chk("R7 nothing consumed", fidx, 0);
   endtask

   task automatic t_short();
      start(1'b1, 4);
      add_sof(); add_data(3); add_even(); add_parity(2);
      add(9'h055, 9'h055, 1, "R8");
      for (int i = 0; i < 3; i++) add(I_, I_, 0, "R8");
      run();
      chk("R8 parity abandoned", fidx, 2);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_bypass();
      t_even();
      t_odd();
      t_empty();
      t_short();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule